// File: doc/BRIEF.md
# Status Register with Block-Lock Protection

This block keeps the status byte of a serial flash device and rules on every request that would change the array or the status byte. It holds four pieces of state: a write-permit latch, a busy flag, a two-bit lock selector and a bit that arms the external protect pin. The SPI front-end hands it decoded commands as single-cycle strobes. The protect pin comes in as a plain level, and the array controller sends a one-cycle done pulse when a programming cycle finishes.

For each program or status-write strobe, the block answers with a grant or a deny strobe in the same cycle. The strobes have no back-pressure. A request is always answered in the cycle it arrives, and a request that cannot be served is denied, never held. A grant starts a busy cycle that lasts until the done pulse. The stored lock and pin-arm bits come from reset parameters. These stand in for nonvolatile storage.

Top module: `status_lock_ctrl`

## Requirements
- R1: After reset the status byte is {PRESET_PPEN, 000, PRESET_LOCK, 0, 0}. With the default parameters this is 8'h00.
- R2: When idle, the status byte is laid out as follows: bit 7 is the pin-arm bit, bits 6 to 4 read 0, bits 3:2 are the lock selector, bit 1 is the write-permit latch and bit 0 is the busy flag.
- R3: When idle, `en_set` sets the latch and `en_clr` clears it. If both arrive in the same cycle, the clear wins. Either change shows in the status byte one cycle later.
- R4: While busy, the status byte reads 8'hFF, and `en_set` and `en_clr` have no effect on the latch.
- R5: A program or status-write request is granted only when the latch is set. If `swr_req` and `prog_req` arrive together, the program request is denied.
- R6: A program request is denied when its address falls in the locked range. The locked range depends on the lock selector: 00 locks nothing, 01 locks the top quarter (address >= 3/4 of the array), 10 locks the top half, and 11 locks every address.
- R7: When the pin-arm bit is 1 and `prot_pin` is low, both request kinds are denied. When the pin-arm bit is 0, the level of `prot_pin` has no effect.
- R8: A granted status write loads only bits 7, 3 and 2 from `swr_data`, and it starts a busy cycle just as a granted program does.
- R9: A denied request leaves the latch unchanged and does not start a busy cycle.
- R10: A done pulse while busy ends the busy cycle and clears the latch. A done pulse while idle is ignored.
- R11: Every request received while busy is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set | input | 1 | Strobe: set write-permit latch |
| en_clr | input | 1 | Strobe: clear write-permit latch |
| prog_req | input | 1 | Strobe: array program request |
| prog_addr | input | ADDR_W | Start address of the program request |
| swr_req | input | 1 | Strobe: status-write request |
| swr_data | input | 8 | New status byte for a status write |
| prot_pin | input | 1 | Protect pin level, low means protect |
| array_done | input | 1 | One-cycle pulse: program cycle finished |
| status_byte | output | 8 | Status byte for reads |
| prog_grant | output | 1 | Program request granted (same cycle) |
| prog_deny | output | 1 | Program request denied (same cycle) |
| swr_grant | output | 1 | Status write granted (same cycle) |
| swr_deny | output | 1 | Status write denied (same cycle) |

## Verification
The hardest states to reach are the lock boundaries combined with the pin-arm setting. Each lock selector value and each pin-arm value can only be reached by a granted status write followed by a done pulse. The stimulus therefore walks the configuration through 11, 01, 10 and 00 in sequence. At each step it first re-sets the latch, then probes the addresses just below and at the lock boundary. It also drives `prot_pin` low once with the pin armed and once with it disarmed. A denied status write is read back through the status byte to confirm that the latch survived.

// File: rtl/slk_pkg.sv
package slk_pkg;
  typedef logic [1:0] lock_sel_t;
  localparam logic [7:0] CFG_MASK  = 8'h8C;
  localparam logic [7:0] BUSY_BYTE = 8'hFF;
endpackage

// File: rtl/slk_range_check.sv
module slk_range_check
  import slk_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  lock_sel_t         lock_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam logic [ADDR_W:0] HALF_BASE = (ADDR_W+1)'(DEPTH / 2);
  localparam logic [ADDR_W:0] QTR_BASE  = (ADDR_W+1)'((DEPTH / 4) * 3);

  logic [ADDR_W:0] base;
  logic            none;

  always_comb begin
    none = 1'b0;
    unique case (lock_sel)
      2'b00:   begin base = '0; none = 1'b1; end
      2'b01:   base = QTR_BASE;
      2'b10:   base = HALF_BASE;
      default: base = '0;
    endcase
    locked = !none && ({1'b0, addr} >= base);
  end
endmodule

// File: rtl/slk_enable_latch.sv
module slk_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cmd,
  input  logic clr_cmd,
  input  logic busy,
  input  logic done,
  output logic latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            latch_q <= 1'b0;
    else if (busy) begin
      if (done)            latch_q <= 1'b0;
    end
    else if (clr_cmd)      latch_q <= 1'b0;
    else if (set_cmd)      latch_q <= 1'b1;
  end

  // R10
  done_clears_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !latch_q);
  // R4
  busy_holds_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (latch_q == $past(latch_q)));
endmodule

// File: rtl/slk_busy_track.sv
module slk_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy <= 1'b0;
    else if (start) busy <= 1'b1;
    else if (done)  busy <= 1'b0;
  end

  // R8
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R10
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && done) |=> !busy);
endmodule

// File: rtl/status_lock_ctrl.sv
module status_lock_ctrl
  import slk_pkg::*;
#(
  parameter int              ADDR_W      = 14,
  parameter bit              PRESET_PPEN = 1'b0,
  parameter logic [1:0]      PRESET_LOCK = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              swr_req,
  input  logic [7:0]        swr_data,
  input  logic              prot_pin,
  input  logic              array_done,
  output logic [7:0]        status_byte,
  output logic              prog_grant,
  output logic              prog_deny,
  output logic              swr_grant,
  output logic              swr_deny
);
  localparam logic [7:0] CFG_RESET = {PRESET_PPEN, 3'b000, PRESET_LOCK, 2'b00};

  logic [7:0] cfg_q;
  logic       latch_q, busy, lock_hit, pin_block, common_ok;
  lock_sel_t  lock_sel;

  assign lock_sel  = cfg_q[3:2];
  assign pin_block = cfg_q[7] && !prot_pin;
  assign common_ok = !busy && latch_q && !pin_block;

  assign swr_grant  = swr_req && common_ok;
  assign swr_deny   = swr_req && !common_ok;
  assign prog_grant = prog_req && !swr_req && common_ok && !lock_hit;
  assign prog_deny  = prog_req && !prog_grant;

  slk_range_check #(.ADDR_W(ADDR_W)) u_range (
    .lock_sel (lock_sel),
    .addr     (prog_addr),
    .locked   (lock_hit)
  );

  slk_enable_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_cmd (en_set),
    .clr_cmd (en_clr),
    .busy    (busy),
    .done    (array_done),
    .latch_q (latch_q)
  );

  slk_busy_track u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prog_grant || swr_grant),
    .done  (array_done),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= CFG_RESET;
    else if (swr_grant) cfg_q <= swr_data & CFG_MASK;
  end

  always_comb begin
    if (busy) status_byte = BUSY_BYTE;
    else      status_byte = cfg_q | {6'b000000, latch_q, 1'b0};
  end

  // R5
  grant_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_grant || swr_grant) |-> latch_q);
  // R6
  locked_addr_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && lock_hit) |-> prog_deny);
  // R7
  armed_pin_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[7] && !prot_pin && (swr_req || prog_req)) |-> !(swr_grant || prog_grant));
  // R11
  busy_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (prog_req || swr_req)) |-> !(prog_grant || swr_grant));
  // R9
  deny_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (prog_deny || swr_deny) && !prog_grant && !swr_grant) |=> !busy);
  // R4
  busy_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (status_byte == 8'hFF));
endmodule

// File: tb/status_lock_ctrl_tb.sv
module status_lock_ctrl_tb;
  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_set = 0, en_clr = 0, prog_req = 0, swr_req = 0, prot_pin = 1, array_done = 0;
  logic [ADDR_W-1:0] prog_addr = '0;
  logic [7:0] swr_data = '0;
  logic [7:0] status_byte;
  logic prog_grant, prog_deny, swr_grant, swr_deny;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  status_lock_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
    .prog_req(prog_req), .prog_addr(prog_addr), .swr_req(swr_req),
    .swr_data(swr_data), .prot_pin(prot_pin), .array_done(array_done),
    .status_byte(status_byte), .prog_grant(prog_grant), .prog_deny(prog_deny),
    .swr_grant(swr_grant), .swr_deny(swr_deny)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic latch_cmd(logic s, logic c);
    en_set = s; en_clr = c; tick(); en_set = 0; en_clr = 0;
  endtask

  task automatic done_pulse();
    array_done = 1; tick(); array_done = 0;
  endtask

  // drives one program request; returns {grant,deny} seen in that cycle
  task automatic prog(logic [ADDR_W-1:0] a, output logic [1:0] gd);
    prog_req = 1; prog_addr = a; #1; gd = {prog_grant, prog_deny};
    tick(); prog_req = 0;
  endtask

  task automatic swr(logic [7:0] d, output logic [1:0] gd);
    swr_req = 1; swr_data = d; #1; gd = {swr_grant, swr_deny};
    tick(); swr_req = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset status", status_byte, 8'h00);
  endtask

  task automatic t_latch();
    latch_cmd(1, 0); chk("R3 set latch", status_byte, 8'h02);
    latch_cmd(1, 1); chk("R3 clear wins", status_byte, 8'h00);
    latch_cmd(1, 0); latch_cmd(0, 1); chk("R3 clear latch", status_byte, 8'h00);
  endtask

  task automatic t_no_latch();
    logic [1:0] gd;
    prog(14'h0000, gd);
    chk("R5 deny without latch", {6'b0, gd}, 8'h01);
    chk("R9 no busy after deny", status_byte, 8'h00);
  endtask

  task automatic t_program();
    logic [1:0] gd;
    latch_cmd(1, 0);
    prog(14'h0100, gd);
    chk("R5 grant with latch", {6'b0, gd}, 8'h02);
    chk("R4 busy reads FF", status_byte, 8'hFF);
    latch_cmd(0, 1);
    prog(14'h0000, gd);
    chk("R11 deny while busy", {6'b0, gd}, 8'h01);
    done_pulse();
    chk("R10 done clears latch and busy", status_byte, 8'h00);
  endtask

  task automatic t_busy_ignores_clear();
    logic [1:0] gd;
    latch_cmd(1, 0);
    prog(14'h0000, gd);
    latch_cmd(0, 1);
    latch_cmd(1, 0);
    swr_req = 1; #1; chk("R11 status write denied while busy", {6'b0, swr_grant, swr_deny}, 8'h01);
    tick(); swr_req = 0;
    chk("R4 still FF", status_byte, 8'hFF);
    done_pulse();
    chk("R4 R10 latch cleared by done only", status_byte, 8'h00);
  endtask

  task automatic t_status_write();
    logic [1:0] gd;
    latch_cmd(1, 0);
    swr(8'hFF, gd);
    chk("R8 status write granted", {6'b0, gd}, 8'h02);
    chk("R8 busy after status write", status_byte, 8'hFF);
    done_pulse();
    chk("R8 R2 only bits 7,3,2 stored", status_byte, 8'h8C);
  endtask

  task automatic t_pin();
    logic [1:0] gd;
    latch_cmd(1, 0);
    prot_pin = 0;
    swr(8'h84, gd);
    chk("R7 armed pin low denies", {6'b0, gd}, 8'h01);
    chk("R9 latch kept after deny", status_byte, 8'h8E);
    prot_pin = 1;
    swr(8'h84, gd);
    chk("R7 pin high allows", {6'b0, gd}, 8'h02);
    done_pulse();
    chk("R2 lock 01 armed", status_byte, 8'h84);
  endtask

  task automatic t_locks();
    logic [1:0] gd;
    // selector 01: top quarter locked
    latch_cmd(1, 0);
    prog(14'h3000, gd); chk("R6 quarter locks 3000", {6'b0, gd}, 8'h01);
    chk("R9 latch kept after lock deny", status_byte, 8'h86);
    prog(14'h2FFF, gd); chk("R6 quarter frees 2FFF", {6'b0, gd}, 8'h02);
    done_pulse();
    // selector 10, pin disarmed
    latch_cmd(1, 0);
    swr(8'h08, gd); done_pulse();
    chk("R2 lock 10 disarmed", status_byte, 8'h08);
    latch_cmd(1, 0);
    prot_pin = 0;
    prog(14'h2000, gd); chk("R6 half locks 2000", {6'b0, gd}, 8'h01);
    prog(14'h1FFF, gd); chk("R7 pin ignored when disarmed", {6'b0, gd}, 8'h02);
    done_pulse();
    // selector 11
    latch_cmd(1, 0);
    swr(8'h0C, gd); chk("R7 status write ignores pin when disarmed", {6'b0, gd}, 8'h02);
    done_pulse();
    prot_pin = 1;
    latch_cmd(1, 0);
    prog(14'h0000, gd); chk("R6 whole array locks 0000", {6'b0, gd}, 8'h01);
    // both requests together
    swr_req = 1; swr_data = 8'h00; prog_req = 1; prog_addr = '0; #1;
    chk("R5 simultaneous: swr wins", {4'b0, swr_grant, swr_deny, prog_grant, prog_deny}, 8'h09);
    tick(); swr_req = 0; prog_req = 0;
    done_pulse();
    // selector 00
    latch_cmd(1, 0);
    prog(14'h3FFF, gd); chk("R6 selector 00 locks nothing", {6'b0, gd}, 8'h02);
    done_pulse();
  endtask

  task automatic t_idle_done();
    latch_cmd(1, 0);
    done_pulse();
    chk("R10 idle done ignored", status_byte, 8'h02);
  endtask

  initial begin
    #1;
    @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_latch();
    t_no_latch();
    t_program();
    t_busy_ignores_clear();
    t_status_write();
    t_pin();
    t_locks();
    t_idle_done();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule